// File: doc/BRIEF.md
# Two-Clock Scan Path State Register

This block is the state register of a small sequential circuit, built so that the register can be tested through a serial chain. Each storage element has two data ports and two clock enables. On a system-clock pulse an element takes its value from the next-state logic. On a test-clock pulse it takes the value of its neighbour toward the serial input. The elements therefore form a shift register from `scan_in` to `scan_out`.

In normal operation only the system clock is pulsed, and the circuit steps through its states from its primary inputs. In test mode the bench first shifts a chosen state in with the test clock. It then applies an input vector and checks the outputs, pulses the system clock once, and shifts the resulting state out serially.

Both clocks are modelled as enables on one free-running clock `clk`. Raising both enables in the same cycle is treated as an error. A small example circuit with two primary inputs, three state bits and two outputs is included so that the register can be exercised.

Top module: `scanpath_seq_unit`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, the state, `scan_out` and `clk_clash` are all 0 after that edge. Reset takes priority over both enables.
- R2: A cycle with `sys_en`=1 and `tst_en`=0 loads the state from the next-state function, where `x`=`x_in` and `q`=`state_out`: `n[0] = x[0] ^ q[2]`, `n[1] = q[0] | (x[1] & ~q[2])`, `n[2] = (q[1] & x[0]) ^ x[1]`.
- R3: A cycle with `tst_en`=1 and `sys_en`=0 shifts the chain. Bit 0 takes `scan_in`, and each bit i>0 takes the old bit i-1. The chain runs from `scan_in` to bit 0, then up to bit 2, so a state shifted in most significant bit first ends up in place after three pulses.
- R4: `scan_out` is a register. On each shift cycle it takes the old value of state bit 2, the bit nearest the serial output. In every other non-reset cycle it holds its value. Shifting a state out therefore shows bit 2, then bit 1, then bit 0, one per pulse.
- R5: A cycle with both enables low leaves the state and `scan_out` unchanged.
- R6: A cycle with both enables high changes neither the state nor `scan_out`. `clk_clash` is 1 after that edge. After any other non-reset cycle `clk_clash` is 0.
- R7: `z_out` is combinational from the present state and `x_in`: `z[0] = q[0] ^ q[1] ^ x[1]`, `z[1] = (q[2] & x[0]) | (q[1] & ~q[0])`.
- R8: `state_out` always shows the present register contents, with bit i equal to chain element i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that both enables qualify |
| rst | input | 1 | Synchronous reset, active high |
| sys_en | input | 1 | System-clock pulse: parallel load of the next state |
| tst_en | input | 1 | Test-clock pulse: serial shift of the chain |
| scan_in | input | 1 | Serial data entering state bit 0 |
| x_in | input | 2 | Primary inputs of the example circuit |
| z_out | output | 2 | Primary outputs of the example circuit |
| state_out | output | 3 | Present state |
| scan_out | output | 1 | Registered serial output taken from state bit 2 |
| clk_clash | output | 1 | Set after a cycle in which both enables were high |

## Verification
All eight states are scanned in, and each is paired with every value of the two primary inputs. One system pulse follows, and the result is scanned out. This tells apart every entry of the next-state table and every output term, and shows that the serial order and the registered output delay are right. While a new state shifts in, the old state streams out, which shows that the chain links do not cross. Idle cycles, clash cycles and a reset asserted together with both enables show that the register holds, flags the clash and obeys reset priority.

// File: rtl/scanpath_pkg.sv
package scanpath_pkg;
    localparam int STATE_W = 3;
    localparam int IN_W    = 2;
    localparam int OUT_W   = 2;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_CLASH   = 2'd3
    } op_e;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import scanpath_pkg::*;
(
    input  logic sys_en,
    input  logic tst_en,
    output op_e  op
);
    always_comb begin
        unique case ({sys_en, tst_en})
            2'b10:   op = OP_CAPTURE;
            2'b01:   op = OP_SHIFT;
            2'b11:   op = OP_CLASH;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/dual_port_cell.sv
module dual_port_cell (
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  logic shf_en,
    input  logic d_cap,
    input  logic d_shf,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (cap_en)
            q_d = d_cap;
        else if (shf_en)
            q_d = d_shf;
        if (rst)
            q_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/state_chain.sv
module state_chain
    import scanpath_pkg::*;
#(
    parameter int WIDTH = STATE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] state
);
    logic [WIDTH:0] link;
    logic           cap_en;
    logic           shf_en;

    assign cap_en  = (op == OP_CAPTURE);
    assign shf_en  = (op == OP_SHIFT);
    assign link[0] = ser_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        dual_port_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .cap_en (cap_en),
            .shf_en (shf_en),
            .d_cap  (par_in[i]),
            .d_shf  (link[i]),
            .q      (link[i+1])
        );
    end

    assign state = link[WIDTH:1];
endmodule

// File: rtl/example_logic.sv
module example_logic
    import scanpath_pkg::*;
(
    input  logic [IN_W-1:0]    x,
    input  logic [STATE_W-1:0] q,
    output logic [STATE_W-1:0] n,
    output logic [OUT_W-1:0]   z
);
    always_comb begin
        n[0] = x[0] ^ q[2];
        n[1] = q[0] | (x[1] & ~q[2]);
        n[2] = (q[1] & x[0]) ^ x[1];
        z[0] = q[0] ^ q[1] ^ x[1];
        z[1] = (q[2] & x[0]) | (q[1] & ~q[0]);
    end
endmodule

// File: rtl/scanpath_seq_unit.sv
module scanpath_seq_unit
    import scanpath_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sys_en,
    input  logic               tst_en,
    input  logic               scan_in,
    input  logic [IN_W-1:0]    x_in,
    output logic [OUT_W-1:0]   z_out,
    output logic [STATE_W-1:0] state_out,
    output logic               scan_out,
    output logic               clk_clash
);
    typedef struct packed {
        logic so;
        logic err;
    } edge_t;

    op_e                op;
    logic [STATE_W-1:0] q;
    logic [STATE_W-1:0] nxt;
    edge_t              r_d, r_q;

    scan_ctrl u_ctrl (
        .sys_en (sys_en),
        .tst_en (tst_en),
        .op     (op)
    );

    example_logic u_logic (
        .x (x_in),
        .q (q),
        .n (nxt),
        .z (z_out)
    );

    state_chain #(.WIDTH(STATE_W)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ser_in (scan_in),
        .par_in (nxt),
        .state  (q)
    );

    always_comb begin
        r_d     = r_q;
        r_d.err = (op == OP_CLASH);
        if (op == OP_SHIFT)
            r_d.so = q[STATE_W-1];
        if (rst)
            r_d = '0;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_out = q;
    assign scan_out  = r_q.so;
    assign clk_clash = r_q.err;
endmodule

// File: rtl/scanpath_seq_checker.sv
module scanpath_seq_checker
    import scanpath_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               sys_en,
    input logic               tst_en,
    input logic               scan_in,
    input logic [STATE_W-1:0] state_out,
    input logic               scan_out,
    input logic               clk_clash
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (state_out == '0) && !scan_out && !clk_clash);

    a_r3_shift_moves_chain: assert property (@(posedge clk) disable iff (rst)
        (tst_en && !sys_en) |=>
            (state_out[STATE_W-1:1] == $past(state_out[STATE_W-2:0])) &&
            (state_out[0] == $past(scan_in)));

    a_r4_serial_out_tail: assert property (@(posedge clk) disable iff (rst)
        (tst_en && !sys_en) |=> scan_out == $past(state_out[STATE_W-1]));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!tst_en && !sys_en) |=> $stable(state_out) && $stable(scan_out));

    a_r6_clash_holds_flags: assert property (@(posedge clk) disable iff (rst)
        (tst_en && sys_en) |=> $stable(state_out) && $stable(scan_out) && clk_clash);

    a_r6_no_false_clash: assert property (@(posedge clk) disable iff (rst)
        !(tst_en && sys_en) |=> !clk_clash);
endmodule

bind scanpath_seq_unit scanpath_seq_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .sys_en    (sys_en),
    .tst_en    (tst_en),
    .scan_in   (scan_in),
    .state_out (state_out),
    .scan_out  (scan_out),
    .clk_clash (clk_clash)
);

// File: tb/scanpath_seq_unit_test.sv
module scanpath_seq_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sys_en = 1'b0;
    logic       tst_en = 1'b0;
    logic       scan_in = 1'b0;
    logic [1:0] x_in = 2'b00;
    logic [1:0] z_out;
    logic [2:0] state_out;
    logic       scan_out;
    logic       clk_clash;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference
    int m_state = 0;
    int m_so    = 0;
    int m_err   = 0;

    always #5 clk = ~clk;

    scanpath_seq_unit uut (
        .clk       (clk),
        .rst       (rst),
        .sys_en    (sys_en),
        .tst_en    (tst_en),
        .scan_in   (scan_in),
        .x_in      (x_in),
        .z_out     (z_out),
        .state_out (state_out),
        .scan_out  (scan_out),
        .clk_clash (clk_clash)
    );

    function automatic int bitof(int v, int i);
        return (v >> i) & 1;
    endfunction

    function automatic int ref_next(int q, int x);
        int n0, n1, n2;
        n0 = bitof(x, 0) ^ bitof(q, 2);
        n1 = bitof(q, 0) | (bitof(x, 1) & (1 - bitof(q, 2)));
        n2 = (bitof(q, 1) & bitof(x, 0)) ^ bitof(x, 1);
        return n0 + 2 * n1 + 4 * n2;
    endfunction

    function automatic int ref_out(int q, int x);
        int z0, z1;
        z0 = bitof(q, 0) ^ bitof(q, 1) ^ bitof(x, 1);
        z1 = (bitof(q, 2) & bitof(x, 0)) | (bitof(q, 1) & (1 - bitof(q, 0)));
        return z0 + 2 * z1;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        check({req, " state"}, int'(state_out), m_state);
        check({req, " scan_out"}, int'(scan_out), m_so);
        check({req, " clash"}, int'(clk_clash), m_err);
        check("R7 z_out", int'(z_out), ref_out(m_state, int'(x_in)));
    endtask

    // one clock: inputs set now (after a negedge), model steps at the edge,
    // outputs compared at the following negedge
    task automatic tick(bit r, bit s, bit t, bit si, string req);
        int old;
        rst = r; sys_en = s; tst_en = t; scan_in = si;
        @(posedge clk);
        old = m_state;
        if (r) begin
            m_state = 0; m_so = 0; m_err = 0;
        end else begin
            m_err = (s && t) ? 1 : 0;
            if (s && !t)
                m_state = ref_next(old, int'(x_in));
            else if (t && !s) begin
                m_so    = bitof(old, 2);
                m_state = ((old << 1) & 6) | int'(si);
            end
        end
        @(negedge clk);
        compare_all(req);
    endtask

    task automatic scan_word(int v);
        for (int b = 2; b >= 0; b--)
            tick(0, 0, 1, bitof(v, b) != 0, "R3/R4 shift");
    endtask

    initial begin
        @(negedge clk);
        tick(1, 0, 0, 0, "R1 reset");
        check("R1 reset state", int'(state_out), 0);

        for (int s = 0; s < 8; s++) begin
            for (int x = 0; x < 4; x++) begin
                x_in = x[1:0];
                scan_word(s);
                check("R8 scanned-in state", int'(state_out), s);
                check("R7 outputs", int'(z_out), ref_out(s, x));
                tick(0, 1, 0, 0, "R2 capture");
                check("R2 next state", int'(state_out), ref_next(s, x));
                tick(0, 0, 0, 1, "R5 idle");
                if (x == 2)
                    tick(0, 1, 1, 1, "R6 clash");
                tick(0, 0, 0, 0, "R6 clash cleared");
                // scan out the captured state; new state goes in behind it
                scan_word(7 - s);
            end
        end

        // serial order of a known word: 100 streams out 1,0,0
        scan_word(4);
        tick(0, 0, 1, 0, "R4 first out");
        check("R4 msb first", int'(scan_out), 1);
        tick(0, 0, 1, 0, "R4 second out");
        check("R4 middle bit", int'(scan_out), 0);

        // reset beats both enables
        scan_word(5);
        tick(0, 1, 1, 0, "R6 clash");
        tick(1, 1, 1, 1, "R1 reset priority");
        check("R1 clash cleared", int'(clk_clash), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule